// File: doc/BRIEF.md
# FIFO Threshold Interrupt Unit

This block sits between a host register port and a serial transaction engine. It holds two byte queues of sixteen entries each: one carries bytes from the host to the engine, and the other carries bytes from the engine back to the host. Each queue has a programmable threshold. The unit derives level flags from the two fill counts and latches protocol events that the engine reports as one-cycle pulses. It gathers all of these into one interrupt status word. A mask selects which status bits drive the single interrupt line.

The host writes transmit bytes and reads receive bytes through the same register port it uses for configuration. The engine side uses valid/ready handshakes:

- **Transmit stream.** `tx_valid_o` is high whenever a byte is available. The engine takes the byte in any cycle where it also holds `tx_ready_i` high.
- **Receive stream.** The engine offers a byte with `rx_valid_i`. The byte is taken only in a cycle where `rx_ready_o` is high. `rx_ready_o` drops when the receive queue is full or is being flushed. The engine must then keep the byte and offer it again later.

Either queue can be emptied by a flush request. The flush bit reads back as one until the drain has finished.

Register map (word index on `reg_addr_i`):

| Index | Name | Access |
|---|---|---|
| 0 | control | flush bits |
| 1 | transmit threshold | read/write |
| 2 | receive threshold | read/write |
| 3 | mask | read/write |
| 4 | raw status | read-only |
| 5 | masked status | read-only |
| 6 | clear | write-only, reads 0 |
| 7 | transmit data | write-only, reads 0 |
| 8 | receive data | read |
| 9 | levels | read-only |
| 10–15 | unused | read 0 |

Top module: `fifo_irq_unit`

## Requirements
- R1: Bytes leave each queue in the order they entered, and each queue holds 16 entries. The head of the transmit queue is presented on `tx_data_o` with `tx_valid_o` high whenever the queue is non-empty and not flushing. It is removed in a cycle with `tx_ready_i` high. A host write to index 7 appends `reg_wdata_i[7:0]`. Reading index 8 returns the head of the receive queue in bits [7:0], or 0 when the queue is empty or flushing. The head is removed only when `reg_rd_i` is high. The levels register (index 9) shows the transmit count in bits [4:0] and the receive count in bits [20:16].
- R2: Raw status bit 0 is "transmit empty" (count = 0), bit 1 is "transmit nearly empty" (count ≤ transmit threshold) and bit 2 is "transmit full" (count = 16). All three follow the count live.
- R3: Raw status bit 4 is "receive empty", bit 5 is "receive nearly full" (count ≥ receive threshold) and bit 6 is "receive full". All three follow the count live.
- R4: A write to index 7 while the transmit queue is full (and not flushing) sets sticky bit 3 (overrun). The byte is discarded and the count is unchanged. A pop in the same cycle does not make room for the write.
- R5: One-cycle pulses on the event inputs set sticky bits one cycle later:
  - bit 19: transaction done;
  - bit 24: arbitration lost;
  - bit 25: bus error;
  - bit 28: done without stop.
- R6: Writing index 6 clears those sticky bits where the written data is 1 and the bit lies within 0x131F007F. Level bits are unaffected and keep their live value. A sticky bit that is set and cleared in the same cycle ends up set.
- R7: The mask (index 3) stores bits [28:0] of the write; bits [31:29] read as 0. Masked status (index 5) is raw AND mask. `irq_o` is high exactly when masked status is non-zero.
- R8: Writing index 0 with bit 7 (transmit) or bit 8 (receive) set starts a flush of that queue. The bit reads as 1 while the flush is in progress. The flush removes one entry per cycle and the bit clears in the cycle after the count reaches 0. For a queue holding N entries, the bit therefore reads 1 for N+1 cycles after the write edge. A new request made while a flush is in progress has no effect.
- R9: While a queue is flushing, all normal traffic to it is ignored:
  - `tx_valid_o` is low and the transmit queue drops host writes (without raising overrun);
  - `rx_ready_o` is low and receive-data reads remove nothing and return 0.
- R10: `rx_ready_o` is low whenever the receive queue holds 16 entries; a byte is accepted only in a cycle with `rx_valid_i` and `rx_ready_o` both high.
- R11: The threshold registers (indexes 1 and 2) store bits [3:0] of the write and read back those four bits only.
- R12: After reset:
  - both queues are empty and not flushing;
  - mask and sticky bits are 0;
  - raw status reads 0x33;
  - `irq_o`, `tx_valid_o` are low and `rx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register word index for reads and writes |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rd_i | input | 1 | Read strobe; pops the receive queue at index 8 |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| tx_valid_o | output | 1 | Transmit byte available to the engine |
| tx_ready_i | input | 1 | Engine takes the transmit byte |
| tx_data_o | output | 8 | Transmit byte at the queue head |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_ready_o | output | 1 | Receive queue can accept a byte |
| rx_data_i | input | 8 | Received byte |
| evt_done_i | input | 1 | Pulse: transaction finished with stop |
| evt_done_nostop_i | input | 1 | Pulse: transaction finished without stop |
| evt_arb_lost_i | input | 1 | Pulse: arbitration lost |
| evt_bus_err_i | input | 1 | Pulse: bus error |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The hardest situation to reach from the ports is a flush that drains a full queue while both sides keep pushing and popping. Reaching it needs sixteen host writes with the engine stalled. The bench sets this up directly: it fills the transmit queue with `tx_ready_i` held low, provokes an overrun, then flushes while host writes and engine pulls continue. It does the same on the receive side with `rx_valid_i` held high until `rx_ready_o` drops. In idle cycles, long random runs sweep every readable register without side effects. This exposes set/clear collisions and threshold edges that the directed cases do not reach.

// File: rtl/fiq_pkg.sv
`timescale 1ns/100ps
package fiq_pkg;
  // interrupt status bit positions (decoded by software, kept fixed)
  localparam int B_TX_EMPTY   = 0;
  localparam int B_TX_NEMPTY  = 1;
  localparam int B_TX_FULL    = 2;
  localparam int B_TX_OVR     = 3;
  localparam int B_RX_EMPTY   = 4;
  localparam int B_RX_NFULL   = 5;
  localparam int B_RX_FULL    = 6;
  localparam int B_DONE       = 19;
  localparam int B_ARB_LOST   = 24;
  localparam int B_BUS_ERR    = 25;
  localparam int B_DONE_NS    = 28;

  localparam int STAT_W = 32;

  localparam logic [STAT_W-1:0] CLEARABLE = 32'h131F_007F;
  localparam logic [STAT_W-1:0] WRITABLE  = 32'h1FFF_FFFF;
  localparam logic [STAT_W-1:0] STICKY    =
    (STAT_W'(1) << B_TX_OVR) | (STAT_W'(1) << B_DONE) | (STAT_W'(1) << B_ARB_LOST) |
    (STAT_W'(1) << B_BUS_ERR) | (STAT_W'(1) << B_DONE_NS);

  // control bits
  localparam int FL_TX = 7;
  localparam int FL_RX = 8;

  // register word indexes
  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_TXTHR  = 4'd1;
  localparam logic [3:0] A_RXTHR  = 4'd2;
  localparam logic [3:0] A_MASK   = 4'd3;
  localparam logic [3:0] A_RAW    = 4'd4;
  localparam logic [3:0] A_MSK    = 4'd5;
  localparam logic [3:0] A_CLEAR  = 4'd6;
  localparam logic [3:0] A_TXDATA = 4'd7;
  localparam logic [3:0] A_RXDATA = 4'd8;
  localparam logic [3:0] A_LEVEL  = 4'd9;

  localparam int RX_LEVEL_POS = 16;
endpackage

// File: rtl/fiq_byte_fifo.sv
`timescale 1ns/100ps
module fiq_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [DW-1:0]                push_data_i,
  input  logic                         pop_i,
  output logic [DW-1:0]                pop_data_o,
  input  logic                         flush_i,
  output logic                         busy_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          do_push, do_pop;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == FULL_CNT);
  assign busy_o     = busy_q;
  assign count_o    = cnt_q;
  assign pop_data_o = mem_q[rd_q];

  // a flush drains one entry per cycle and locks out normal traffic
  assign do_push = push_i && !full_o && !busy_q;
  assign do_pop  = !empty_o && (busy_q || pop_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      if (busy_q && empty_o) busy_q <= 1'b0;
      else if (flush_i)      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data_i;
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  assert_drain_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !empty_o) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == '0));

  assert_no_fill_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/fiq_irq_status.sv
`timescale 1ns/100ps
module fiq_irq_status
  import fiq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] level_i,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_we_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] masked_o,
  output logic [STAT_W-1:0] mask_o
);
  logic [STAT_W-1:0] sticky_q, mask_q, clr_vec, set_vec;

  assign clr_vec = clr_we_i ? (wdata_i & CLEARABLE) : '0;
  assign set_vec = set_i & STICKY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      mask_q   <= '0;
    end else begin
      // a new event outranks a clear arriving in the same cycle
      sticky_q <= (sticky_q & ~clr_vec) | set_vec;
      if (mask_we_i) mask_q <= wdata_i & WRITABLE;
    end
  end

  assign raw_o    = sticky_q | (level_i & ~STICKY);
  assign masked_o = raw_o & mask_q;
  assign mask_o   = mask_q;

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sticky_q) & ~$past(clr_vec)) & ~sticky_q) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((sticky_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/fifo_irq_unit.sv
`timescale 1ns/100ps
module fifo_irq_unit
  import fiq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int THR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [31:0]       reg_rdata_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [DW-1:0]     tx_data_o,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              evt_done_i,
  input  logic              evt_done_nostop_i,
  input  logic              evt_arb_lost_i,
  input  logic              evt_bus_err_i,
  output logic              irq_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             tx_empty, tx_full, tx_busy;
  logic             rx_empty, rx_full, rx_busy;
  logic [DW-1:0]    rx_head;
  logic             wr_ctrl, wr_txdata, wr_mask, wr_clear, rd_rxdata;
  logic [STAT_W-1:0] level_vec, set_vec, raw, masked, mask;

  assign wr_ctrl   = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_txdata = reg_wr_i && (reg_addr_i == A_TXDATA);
  assign wr_mask   = reg_wr_i && (reg_addr_i == A_MASK);
  assign wr_clear  = reg_wr_i && (reg_addr_i == A_CLEAR);
  assign rd_rxdata = reg_rd_i && (reg_addr_i == A_RXDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == A_TXTHR) tx_thr_q <= reg_wdata_i[THR_W-1:0];
      if (reg_addr_i == A_RXTHR) rx_thr_q <= reg_wdata_i[THR_W-1:0];
    end
  end

  fiq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (wr_txdata),
    .push_data_i (reg_wdata_i[DW-1:0]),
    .pop_i       (tx_valid_o && tx_ready_i),
    .pop_data_o  (tx_data_o),
    .flush_i     (wr_ctrl && reg_wdata_i[FL_TX]),
    .busy_o      (tx_busy),
    .count_o     (tx_cnt),
    .empty_o     (tx_empty),
    .full_o      (tx_full)
  );

  fiq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (rx_valid_i && rx_ready_o),
    .push_data_i (rx_data_i),
    .pop_i       (rd_rxdata),
    .pop_data_o  (rx_head),
    .flush_i     (wr_ctrl && reg_wdata_i[FL_RX]),
    .busy_o      (rx_busy),
    .count_o     (rx_cnt),
    .empty_o     (rx_empty),
    .full_o      (rx_full)
  );

  assign tx_valid_o = !tx_empty && !tx_busy;
  assign rx_ready_o = !rx_full && !rx_busy;

  always_comb begin
    level_vec = '0;
    level_vec[B_TX_EMPTY]  = tx_empty;
    level_vec[B_TX_NEMPTY] = (tx_cnt <= CW'(tx_thr_q));
    level_vec[B_TX_FULL]   = tx_full;
    level_vec[B_RX_EMPTY]  = rx_empty;
    level_vec[B_RX_NFULL]  = (rx_cnt >= CW'(rx_thr_q));
    level_vec[B_RX_FULL]   = rx_full;
  end

  always_comb begin
    set_vec = '0;
    set_vec[B_TX_OVR]   = wr_txdata && tx_full && !tx_busy;
    set_vec[B_DONE]     = evt_done_i;
    set_vec[B_ARB_LOST] = evt_arb_lost_i;
    set_vec[B_BUS_ERR]  = evt_bus_err_i;
    set_vec[B_DONE_NS]  = evt_done_nostop_i;
  end

  fiq_irq_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .level_i   (level_vec),
    .set_i     (set_vec),
    .clr_we_i  (wr_clear),
    .mask_we_i (wr_mask),
    .wdata_i   (reg_wdata_i),
    .raw_o     (raw),
    .masked_o  (masked),
    .mask_o    (mask)
  );

  assign irq_o = |masked;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: begin
        reg_rdata_o[FL_TX] = tx_busy;
        reg_rdata_o[FL_RX] = rx_busy;
      end
      A_TXTHR:  reg_rdata_o[THR_W-1:0] = tx_thr_q;
      A_RXTHR:  reg_rdata_o[THR_W-1:0] = rx_thr_q;
      A_MASK:   reg_rdata_o = mask;
      A_RAW:    reg_rdata_o = raw;
      A_MSK:    reg_rdata_o = masked;
      A_RXDATA: if (!rx_empty && !rx_busy) reg_rdata_o[DW-1:0] = rx_head;
      A_LEVEL: begin
        reg_rdata_o[CW-1:0]              = tx_cnt;
        reg_rdata_o[RX_LEVEL_POS +: CW]  = rx_cnt;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txdata && tx_full && !tx_busy) |=> raw[B_TX_OVR]);

  assert_rx_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && rx_valid_i) |=> (rx_cnt <= $past(rx_cnt)));
endmodule

// File: tb/fifo_irq_unit_tb.sv
`timescale 1ns/100ps
module fifo_irq_unit_tb;
  localparam logic [3:0] A_CTRL = 4'd0, A_TXTHR = 4'd1, A_RXTHR = 4'd2, A_MASK = 4'd3,
                         A_RAW = 4'd4, A_MSK = 4'd5, A_CLEAR = 4'd6, A_TXDATA = 4'd7,
                         A_RXDATA = 4'd8, A_LEVEL = 4'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        ev_done = 1'b0, ev_dns = 1'b0, ev_arb = 1'b0, ev_berr = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0]  txq[$];
  logic [7:0]  rxq[$];
  bit          tx_busy_m = 0, rx_busy_m = 0;
  logic [31:0] mask_m = '0, sticky_m = '0;
  logic [3:0]  txthr_m = '0, rxthr_m = '0;

  always #5 clk = ~clk;

  fifo_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .rx_data_i(rx_data),
    .evt_done_i(ev_done), .evt_done_nostop_i(ev_dns), .evt_arb_lost_i(ev_arb),
    .evt_bus_err_i(ev_berr), .irq_o(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_raw();
    logic [31:0] r;
    int tsz, rsz;
    tsz = txq.size();
    rsz = rxq.size();
    r = sticky_m;
    r[0] = (tsz == 0);
    r[1] = (tsz <= int'(txthr_m));
    r[2] = (tsz == 16);
    r[4] = (rsz == 0);
    r[5] = (rsz >= int'(rxthr_m));
    r[6] = (rsz == 16);
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [3:0] a);
    logic [31:0] v;
    v = '0;
    case (a)
      A_CTRL:   begin v[7] = tx_busy_m; v[8] = rx_busy_m; end
      A_TXTHR:  v[3:0] = txthr_m;
      A_RXTHR:  v[3:0] = rxthr_m;
      A_MASK:   v = mask_m;
      A_RAW:    v = exp_raw();
      A_MSK:    v = exp_raw() & mask_m;
      A_RXDATA: if (rxq.size() > 0 && !rx_busy_m) v[7:0] = rxq[0];
      A_LEVEL:  v = 32'(txq.size()) | (32'(rxq.size()) << 16);
      default:  v = '0;
    endcase
    return v;
  endfunction

  function automatic string req_of(input logic [3:0] a);
    case (a)
      A_CTRL, A_LEVEL:  return "R8";
      A_TXTHR, A_RXTHR: return "R11";
      A_MASK, A_MSK:    return "R7";
      A_RXDATA:         return rx_busy_m ? "R9" : "R1";
      default:          return "R1";
    endcase
  endfunction

  task automatic chk_rd(input logic [3:0] a);
    logic [31:0] e;
    e = exp_rd(a);
    if (a == A_RAW) begin
      chk(reg_rdata & 32'h7, e & 32'h7, "R2", "raw tx levels");
      chk(reg_rdata & 32'h8, e & 32'h8, "R4", "raw overrun");
      chk(reg_rdata & 32'h70, e & 32'h70, "R3", "raw rx levels");
      chk(reg_rdata & 32'hFFFF_FF80, e & 32'hFFFF_FF80, "R5 R6", "raw events");
    end else begin
      chk(reg_rdata, e, req_of(a), $sformatf("read index %0d", a));
    end
  endtask

  // one cycle: check outputs against the model, advance the model, cross the edge
  task automatic tick();
    logic [3:0]  keep;
    logic [31:0] raw_e, clr, set;
    int          tsz, rsz;
    bit          push_tx, push_rx, pop_rx, ovr;
    #1;
    raw_e = exp_raw();
    tsz = txq.size();
    rsz = rxq.size();
    chk(32'(tx_valid), 32'(tsz > 0 && !tx_busy_m), tx_busy_m ? "R9" : "R1", "tx_valid");
    if (tsz > 0 && !tx_busy_m) chk(32'(tx_data), 32'(txq[0]), "R1", "tx_data");
    chk(32'(rx_ready), 32'(rsz < 16 && !rx_busy_m), rx_busy_m ? "R9" : "R10", "rx_ready");
    chk(32'(irq), 32'(|(raw_e & mask_m)), "R7", "irq");
    if (!reg_wr && !reg_rd) begin
      keep = reg_addr;
      for (int k = 0; k < 16; k++) begin
        reg_addr = 4'(k);
        #0.2;
        chk_rd(4'(k));
      end
      reg_addr = keep;
      #0.1;
    end else if (reg_rd) begin
      chk_rd(reg_addr);
    end

    ovr = 0;
    if (tx_busy_m) begin
      if (tsz > 0) void'(txq.pop_front());
      else tx_busy_m = 0;
    end else begin
      push_tx = reg_wr && reg_addr == A_TXDATA;
      if (tsz > 0 && tx_ready) void'(txq.pop_front());
      if (push_tx && tsz < 16) txq.push_back(reg_wdata[7:0]);
      ovr = push_tx && tsz == 16;
      if (reg_wr && reg_addr == A_CTRL && reg_wdata[7]) tx_busy_m = 1;
    end
    if (rx_busy_m) begin
      if (rsz > 0) void'(rxq.pop_front());
      else rx_busy_m = 0;
    end else begin
      push_rx = rx_valid && rsz < 16;
      pop_rx  = reg_rd && reg_addr == A_RXDATA && rsz > 0;
      if (pop_rx) void'(rxq.pop_front());
      if (push_rx) rxq.push_back(rx_data);
      if (reg_wr && reg_addr == A_CTRL && reg_wdata[8]) rx_busy_m = 1;
    end
    clr = (reg_wr && reg_addr == A_CLEAR) ? (reg_wdata & 32'h131F_007F) : '0;
    set = (32'(ovr) << 3) | (32'(ev_done) << 19) | (32'(ev_arb) << 24) |
          (32'(ev_berr) << 25) | (32'(ev_dns) << 28);
    sticky_m = (sticky_m & ~clr) | set;
    if (reg_wr && reg_addr == A_MASK)  mask_m  = reg_wdata & 32'h1FFF_FFFF;
    if (reg_wr && reg_addr == A_TXTHR) txthr_m = reg_wdata[3:0];
    if (reg_wr && reg_addr == A_RXTHR) rxthr_m = reg_wdata[3:0];

    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0;
    ev_done = 0; ev_dns = 0; ev_arb = 0; ev_berr = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    tick();
  endtask

  task automatic rd(input logic [3:0] a);
    reg_addr = a; reg_rd = 1;
    tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12: reset state
    reg_addr = A_RAW; #0.5;
    chk(reg_rdata, 32'h33, "R12", "raw after reset");
    chk(32'(irq), 0, "R12", "irq after reset");
    chk(32'(tx_valid), 0, "R12", "tx_valid after reset");
    chk(32'(rx_ready), 1, "R12", "rx_ready after reset");
    @(negedge clk);
    tick();

    // R2/R4: fill transmit queue with engine stalled, then overrun
    wr(A_TXTHR, 32'hFFFF_FFF3);          // R11: only 4 bits stored
    for (int i = 0; i < 17; i++) wr(A_TXDATA, 32'(8'hA0 + i));
    reg_addr = A_LEVEL; #1;
    chk(reg_rdata & 32'h1F, 32'd16, "R4", "tx count unchanged by overrun");
    tick();
    // R7: mask readback drops reserved bits; irq follows
    wr(A_MASK, 32'hFFFF_FFFF);
    tick();
    // R6: clear everything; full level bit stays
    wr(A_CLEAR, 32'hFFFF_FFFF);
    reg_addr = A_RAW; #1;
    chk(reg_rdata & 32'h4, 32'h4, "R6", "level bit survives clear");
    chk(reg_rdata & 32'h8, 32'h0, "R6", "overrun cleared");
    tick();
    // R8/R9: flush full transmit queue while traffic continues
    wr(A_CTRL, 32'h80);
    tx_ready = 1;
    for (int i = 0; i < 18; i++) begin
      if (i % 2 == 0) wr(A_TXDATA, 32'h55);
      else rd(A_CTRL);
    end
    tx_ready = 0;
    // R10: fill receive queue until ready drops
    wr(A_RXTHR, 32'd12);
    rx_valid = 1;
    for (int i = 0; i < 20; i++) begin
      rx_data = 8'(8'h30 + i);
      tick();
    end
    rx_valid = 0;
    rd(A_RXDATA); rd(A_RXDATA);
    // R8: receive flush with a read attempted mid-drain (R9)
    wr(A_CTRL, 32'h100);
    rd(A_RXDATA);
    wr(A_CTRL, 32'h180);                 // request during drain has no effect
    for (int i = 0; i < 16; i++) tick();
    // R5/R6: event set and clear collide
    ev_done = 1; ev_arb = 1; tick();
    ev_berr = 1; ev_dns = 1;
    reg_addr = A_CLEAR; reg_wdata = 32'hFFFF_FFFF; reg_wr = 1;
    tick();
    tick();

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      int op;
      op = int'($urandom_range(0, 99));
      tx_ready = ($urandom_range(0, 2) == 0);
      rx_valid = ($urandom_range(0, 2) == 0);
      rx_data  = 8'($urandom);
      ev_done  = ($urandom_range(0, 29) == 0);
      ev_dns   = ($urandom_range(0, 29) == 0);
      ev_arb   = ($urandom_range(0, 39) == 0);
      ev_berr  = ($urandom_range(0, 39) == 0);
      if (op < 28)      begin reg_addr = A_TXDATA; reg_wdata = $urandom; reg_wr = 1; end
      else if (op < 42) begin reg_addr = A_RXDATA; reg_rd = 1; end
      else if (op < 46) begin reg_addr = ($urandom_range(0,1) == 0) ? A_TXTHR : A_RXTHR;
                              reg_wdata = $urandom; reg_wr = 1; end
      else if (op < 49) begin reg_addr = A_MASK; reg_wdata = $urandom; reg_wr = 1; end
      else if (op < 55) begin reg_addr = A_CLEAR; reg_wdata = $urandom; reg_wr = 1; end
      else if (op < 57) begin reg_addr = A_CTRL; reg_wdata = $urandom & 32'h0000_0FFF;
                              reg_wr = 1; end
      else if (op < 59) begin reg_addr = 4'($urandom); reg_wdata = $urandom; reg_wr = 1; end
      else if (op < 62) begin reg_addr = 4'($urandom); reg_rd = 1; end
      tick();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule